// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Interrupt Sensing

This block is a memory-mapped general-purpose I/O controller for eight pins, reached over an APB-style register bus with byte-wide data. Software sets each pin as input or output, drives output levels, and reads back pin states. Accesses to the data register use the word-address bits as a per-pin mask, so one pin can be changed or sampled without a read-modify-write.

Every pin can raise an interrupt. It can be level-sensitive (high or low) or edge-sensitive (rising, falling, or both edges). Edge events are latched and cleared by writing ones. Level conditions follow the pin directly. Raw status, masked status and a single combined interrupt line are provided.

Pin inputs cross into the bus clock domain through a two-stage synchroniser. Bus writes take effect in the access phase. Read data is captured at the end of the setup phase, so transfers need no wait states.

Top module: `gpio8_ctrl`

## Requirements
- R1: After a synchronous reset, the direction, sense, both-edges, event and enable registers, the stored data, the raw status, `pin_oe`, `pin_out` and `irq` are all zero.
- R2: The direction register at offset 0x400 makes pin n an output when bit n is 1, and `pin_oe` equals it. A write lands on the clock edge of the access phase (`psel` and `penable` high). Read data is valid in the access phase.
- R3: A write to offsets 0x000 to 0x3FC updates only the stored data bits whose mask bit is set. Mask bit n is address bit n+2.
- R4: A read from offsets 0x000 to 0x3FC returns 0 for unmasked bits. A masked output pin returns its stored value. A masked input pin returns its synchronised pin level.
- R5: `pin_out` bit n equals the stored data bit only while pin n is an output, and is 0 otherwise. Data written while a pin is an input is kept and appears once the pin becomes an output.
- R6: With sense bit n set (offset 0x404), raw status bit n (offset 0x414) tracks the synchronised level every cycle. It is 1 for a high level when event bit n (offset 0x40C) is 1, and 1 for a low level when event bit n is 0. It is never latched.
- R7: With sense bit n clear, a rising edge (event bit 1) or a falling edge (event bit 0) sets raw status bit n. The bit stays set until it is cleared.
- R8: With both-edges bit n set (offset 0x408), an edge-sensitive pin latches on either edge, and its event bit is ignored.
- R9: Masked status (offset 0x418) equals raw status AND enable (offset 0x410). `irq` is 1 exactly when masked status is non-zero.
- R10: Writing ones to offset 0x41C clears the matching latched edge bits. Such a write leaves level-sensitive bits unchanged. Offset 0x41C reads 0, and writes to the raw and masked status offsets change nothing.
- R11: If an edge on a pin is detected in the same cycle as a clear of that pin, the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, registered |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output levels, gated by direction |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that bus transfers follow the two-phase pattern: a setup cycle and then one access cycle, with address, direction and write data held steady across both. They also assume `pin_in` may change at any time but is sampled only on the clock. The stimulus drives every bus signal and pin on the falling clock edge and issues transfers only through tasks that produce exactly that pattern. After each pin change, the stimulus waits well past the synchroniser latency before it reads status, except in the single directed case that lines up an edge with a clear.

// File: rtl/gpio8_pkg.sv
`timescale 1ns/1ps
package gpio8_pkg;
  localparam int unsigned GPIO_N = 8;

  // Word selector within the control bank (address bits [4:2]).
  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_LVL  = 3'd1,
    SEL_BOTH = 3'd2,
    SEL_POL  = 3'd3,
    SEL_EN   = 3'd4,
    SEL_RAW  = 3'd5,
    SEL_MSK  = 3'd6,
    SEL_CLR  = 3'd7
  } ctrl_sel_e;
endpackage

// File: rtl/gpio8_sync.sv
`timescale 1ns/1ps
module gpio8_sync #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [N-1:0] chain [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else if (g == 0) chain[g] <= pin_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
  assign prev_o = chain[STAGES];
endmodule

// File: rtl/gpio8_irq.sv
`timescale 1ns/1ps
module gpio8_irq #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_d,
  output logic [N-1:0] raw_q
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pin
      logic rise, fall, lvl_hit, edge_hit;
      always_comb begin
        rise     = sync_i[g] & ~prev_i[g];
        fall     = ~sync_i[g] & prev_i[g];
        lvl_hit  = pol_i[g] ? sync_i[g] : ~sync_i[g];
        edge_hit = both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall);
        if (lvl_i[g]) raw_d[g] = lvl_hit;
        else          raw_d[g] = edge_hit | (raw_q[g] & ~clr_i[g]);
      end
      always_ff @(posedge clk) begin
        if (rst) raw_q[g] <= 1'b0;
        else     raw_q[g] <= raw_d[g];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio8_regs.sv
`timescale 1ns/1ps
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = N + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [N-1:0]      pwdata,
  output logic [N-1:0]      prdata,
  input  logic [N-1:0]      sync_i,
  input  logic [N-1:0]      raw_d,
  input  logic [N-1:0]      raw_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      lvl_q,
  output logic [N-1:0]      both_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      pin_out,
  output logic              irq
);
  localparam int unsigned CTRL_BIT = N + 2;

  logic [N-1:0] data_q;
  logic [N-1:0] data_d, dir_d, lvl_d, both_d, pol_d, en_d;
  logic [N-1:0] mask, rd_val;
  logic         wr_en, rd_setup, data_hit, ctrl_hit;
  ctrl_sel_e    sel;
  logic         unused_addr;

  assign unused_addr = ^paddr[1:0];
  assign wr_en    = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign mask     = paddr[N+1:2];
  assign sel      = ctrl_sel_e'(paddr[4:2]);
  assign data_hit = ~paddr[CTRL_BIT] & ~|paddr[ADDR_W-1:CTRL_BIT+1];
  assign ctrl_hit = paddr[CTRL_BIT] & ~|paddr[ADDR_W-1:CTRL_BIT+1] & ~|paddr[N+1:5];

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    lvl_d  = lvl_q;
    both_d = both_q;
    pol_d  = pol_q;
    en_d   = en_q;
    clr_o  = '0;
    if (wr_en && data_hit) data_d = (data_q & ~mask) | (pwdata & mask);
    if (wr_en && ctrl_hit) begin
      case (sel)
        SEL_DIR:  dir_d  = pwdata;
        SEL_LVL:  lvl_d  = pwdata;
        SEL_BOTH: both_d = pwdata;
        SEL_POL:  pol_d  = pwdata;
        SEL_EN:   en_d   = pwdata;
        SEL_CLR:  clr_o  = pwdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    if (data_hit) begin
      rd_val = ((dir_q & data_q) | (~dir_q & sync_i)) & mask;
    end else if (ctrl_hit) begin
      case (sel)
        SEL_DIR:  rd_val = dir_q;
        SEL_LVL:  rd_val = lvl_q;
        SEL_BOTH: rd_val = both_q;
        SEL_POL:  rd_val = pol_q;
        SEL_EN:   rd_val = en_q;
        SEL_RAW:  rd_val = raw_q;
        SEL_MSK:  rd_val = raw_q & en_q;
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      lvl_q   <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      pin_out <= '0;
      irq     <= 1'b0;
      prdata  <= '0;
    end else begin
      data_q  <= data_d;
      dir_q   <= dir_d;
      lvl_q   <= lvl_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
      en_q    <= en_d;
      pin_out <= data_d & dir_d;
      irq     <= |(raw_d & en_d);
      if (rd_setup) prdata <= rd_val;
    end
  end
endmodule

// File: rtl/gpio8_ctrl.sv
`timescale 1ns/1ps
module gpio8_ctrl #(
  parameter int unsigned N       = gpio8_pkg::GPIO_N,
  parameter int unsigned ADDR_W  = N + 4,
  parameter int unsigned SYNC_FF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [N-1:0]      pwdata,
  output logic [N-1:0]      prdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);
  logic [N-1:0] sync_w, prev_w, lvl_w, both_w, pol_w, en_w, clr_w, raw_d_w, raw_q_w, dir_w;

  gpio8_sync #(.N(N), .STAGES(SYNC_FF)) i_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sync_o(sync_w), .prev_o(prev_w)
  );

  gpio8_irq #(.N(N)) i_irq (
    .clk(clk), .rst(rst), .sync_i(sync_w), .prev_i(prev_w),
    .lvl_i(lvl_w), .both_i(both_w), .pol_i(pol_w), .clr_i(clr_w),
    .raw_d(raw_d_w), .raw_q(raw_q_w)
  );

  gpio8_regs #(.N(N), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .sync_i(sync_w),
    .raw_d(raw_d_w), .raw_q(raw_q_w), .dir_q(dir_w), .lvl_q(lvl_w),
    .both_q(both_w), .pol_q(pol_w), .en_q(en_w), .clr_o(clr_w),
    .pin_out(pin_out), .irq(irq)
  );

  assign pin_oe = dir_w;
endmodule

// File: rtl/gpio8_ctrl_chk.sv
`timescale 1ns/1ps
module gpio8_ctrl_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic         irq,
  input logic [N-1:0] sync_v,
  input logic [N-1:0] lvl_v,
  input logic [N-1:0] pol_v,
  input logic [N-1:0] en_v,
  input logic [N-1:0] raw_v,
  input logic [N-1:0] clr_v
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r5_no_drive_on_input: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  a_r9_irq_is_masked_or: assert property (@(posedge clk) disable iff (rst)
    irq == |(raw_v & en_v));

  a_r6_level_tracks_pin: assert property (@(posedge clk) disable iff (rst || !armed)
    ((raw_v ^ ~($past(sync_v) ^ $past(pol_v))) & $past(lvl_v)) == '0);

  a_r7_edge_latch_holds: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(raw_v) & ~$past(lvl_v) & ~$past(clr_v) & ~raw_v) == '0);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq && raw_v == '0));
endmodule

bind gpio8_ctrl gpio8_ctrl_chk #(.N(N)) i_chk (
  .clk(clk), .rst(rst), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .sync_v(sync_w), .lvl_v(lvl_w), .pol_v(pol_w), .en_v(en_w),
  .raw_v(raw_q_w), .clr_v(clr_w)
);

// File: tb/test_gpio8_ctrl.sv
`timescale 1ns/1ps
module test_gpio8_ctrl;
  localparam logic [11:0] A_DIR = 12'h400, A_LVL = 12'h404, A_BOTH = 12'h408,
                          A_POL = 12'h40C, A_EN = 12'h410, A_RAW = 12'h414,
                          A_MSK = 12'h418, A_CLR = 12'h41C;

  logic clk = 1'b0, rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [7:0] pwdata = '0, prdata, pin_in = '0, pin_out, pin_oe;
  logic irq;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  gpio8_ctrl i_gpio8_ctrl (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic apb_write(input logic [11:0] a, input logic [7:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [7:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk) penable = 1;
    @(negedge clk) begin d = prdata; psel = 0; penable = 0; end
  endtask

  function automatic logic [11:0] data_addr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] dir, data, pins, m);
    return ((dir & data) | (~dir & pins)) & m;
  endfunction

  function automatic logic [7:0] exp_raw(input logic [7:0] lvl, both, pol, oldp, newp);
    logic [7:0] rise, fall, lv, ed;
    rise = newp & ~oldp;
    fall = ~newp & oldp;
    lv   = ~(newp ^ pol);
    ed   = (both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall);
    return (lvl & lv) | (~lvl & ed);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] rd, rd2, data_m, dir_m, lvl, both, pol, en, oldp, newp, er, m, v;
    void'($urandom(32'd4242));
    idle(4);
    rst = 0;
    idle(2);

    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_out", pin_out, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    apb_read(A_DIR, rd); check("R1 dir", rd, 8'h00);
    apb_read(A_EN, rd);  check("R1 enable", rd, 8'h00);
    apb_read(A_RAW, rd); check("R1 raw", rd, 8'h00);

    // R5 data held while input, R2 direction
    apb_write(data_addr(8'hFF), 8'hA5);
    check("R5 input not driven", pin_out, 8'h00);
    apb_write(A_DIR, 8'hF0);
    check("R2 oe follows dir", pin_oe, 8'hF0);
    check("R5 stored value appears", pin_out, 8'hA0);
    apb_read(A_DIR, rd); check("R2 dir readback", rd, 8'hF0);

    // R3 masked writes
    apb_write(data_addr(8'h0C), 8'h00);
    apb_write(data_addr(8'h30), 8'hFF);
    check("R3 masked write", pin_out, 8'hB0);

    // R4 masked reads
    pin_in = 8'h5A;
    idle(4);
    apb_read(data_addr(8'hFF), rd); check("R4 full read", rd, 8'hBA);
    apb_read(data_addr(8'h3C), rd); check("R4 partial read", rd, 8'h38);

    // R10 status writes ignored, clear reads 0
    apb_read(A_RAW, rd);
    apb_write(A_RAW, 8'hFF);
    apb_write(A_MSK, 8'hFF);
    apb_read(A_RAW, rd2); check("R10 raw write ignored", rd2, rd);
    apb_read(A_CLR, rd);  check("R10 clear reads zero", rd, 8'h00);
    apb_write(A_DIR, 8'h00);

    // R6 level sensing
    pin_in = 8'h00;
    apb_write(A_LVL, 8'hFF);
    apb_write(A_POL, 8'h0F);
    apb_write(A_EN, 8'hFF);
    idle(4);
    apb_read(A_RAW, rd); check("R6 level low/high", rd, 8'hF0);
    check("R9 irq level", {7'd0, irq}, 8'h01);
    pin_in = 8'hFF;
    idle(4);
    apb_read(A_RAW, rd); check("R6 level follows pin", rd, 8'h0F);
    apb_write(A_CLR, 8'hFF);
    apb_read(A_RAW, rd); check("R10 level not cleared", rd, 8'h0F);

    // R7 edge sensing
    apb_write(A_LVL, 8'h00);
    apb_write(A_BOTH, 8'h00);
    apb_write(A_CLR, 8'hFF);
    pin_in = 8'h00;
    idle(4);
    apb_read(A_RAW, rd); check("R7 falling edges", rd, 8'hF0);
    pin_in = 8'hFF;
    idle(4);
    apb_read(A_RAW, rd); check("R7 rising added, latched", rd, 8'hFF);
    apb_write(A_CLR, 8'h0F);
    apb_read(A_RAW, rd); check("R10 partial clear", rd, 8'hF0);

    // R8 both edges
    apb_write(A_CLR, 8'hFF);
    apb_write(A_BOTH, 8'h81);
    pin_in = 8'h00;
    idle(4);
    apb_read(A_RAW, rd); check("R8 both-edge falling", rd, 8'hF1);
    pin_in = 8'hFF;
    idle(4);
    apb_read(A_RAW, rd); check("R8 both-edge rising", rd, 8'hFF);

    // R9 masking
    apb_write(A_EN, 8'h0F);
    apb_read(A_MSK, rd); check("R9 masked status", rd, 8'h0F);
    check("R9 irq set", {7'd0, irq}, 8'h01);
    apb_write(A_EN, 8'h00);
    apb_read(A_MSK, rd); check("R9 masked zero", rd, 8'h00);
    check("R9 irq clear", {7'd0, irq}, 8'h00);

    // R11 edge and clear in the same cycle
    apb_write(A_BOTH, 8'hFF);
    apb_write(A_CLR, 8'hFF);
    apb_read(A_RAW, rd); check("R10 all cleared", rd, 8'h00);
    pin_in = 8'hFE;
    idle(4);
    pin_in = 8'hFF;
    @(negedge clk);
    apb_write(A_CLR, 8'h01);
    idle(2);
    apb_read(A_RAW, rd); check("R11 edge wins over clear", rd, 8'h01);
    apb_write(A_CLR, 8'h01);
    apb_read(A_RAW, rd); check("R10 clear without edge", rd, 8'h00);

    // Random mix: data path (R3 R4 R5) and interrupt sensing (R6 R7 R8 R9)
    data_m = 8'hFF & 8'h00;
    apb_write(data_addr(8'hFF), 8'h00);
    for (int i = 0; i < 30; i++) begin
      dir_m = 8'($urandom);
      m = 8'($urandom);
      v = 8'($urandom);
      apb_write(A_DIR, dir_m);
      apb_write(data_addr(m), v);
      data_m = (data_m & ~m) | (v & m);
      check("R5 random pin_out", pin_out, data_m & dir_m);
      m = 8'($urandom);
      apb_read(data_addr(m), rd);
      check("R4 random read", rd, exp_read(dir_m, data_m, pin_in, m));

      lvl = 8'($urandom); both = 8'($urandom); pol = 8'($urandom); en = 8'($urandom);
      apb_write(A_LVL, lvl);
      apb_write(A_BOTH, both);
      apb_write(A_POL, pol);
      apb_write(A_EN, en);
      idle(4);
      apb_write(A_CLR, 8'hFF);
      oldp = pin_in;
      newp = 8'($urandom);
      pin_in = newp;
      idle(5);
      er = exp_raw(lvl, both, pol, oldp, newp);
      apb_read(A_RAW, rd); check("R6/R7/R8 random raw", rd, er);
      apb_read(A_MSK, rd); check("R9 random masked", rd, er & en);
      check("R9 random irq", {7'd0, irq}, {7'd0, |(er & en)});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule